// File: doc/BRIEF.md
# Performance Monitor Counter Bank

A bank of ten 48-bit event counters that sits beside a processor core. Each cycle the core presents a vector of event pulses, indexed by an 8-bit event code, a retired-instruction pulse and its current privilege level (user or kernel). Counter 0 counts clock cycles and counter 1 counts retired instructions. Counters 2 to 9 each count the event whose code software has placed in that counter's select field.

Software reaches the bank through a single-cycle register port. A write takes effect at the next clock edge. A read is combinational on the same address bus. The port has no back-pressure: every access completes in the cycle it is presented, so it carries no valid/ready pair. A counter may be gated by its own enable and by separate user and kernel filter bits. When a counter's bit 47 goes from 0 to 1 through counting, a sticky overflow bit is set. Overflow bits combine with per-counter interrupt enables and a global interrupt mode to drive one of two request lines. They also set an interrupt-active flag that software clears by writing zero to it.

Top module: `pmu_counter_bank`

## Requirements
- R1: After reset every register and counter reads zero, and both interrupt lines are low.
- R2: Counter 0 adds one on every cycle it is allowed to count. Counter 1 adds one on every allowed cycle with `inst_ret_i` high. Counters sit at addresses 16 to 25 (counter i at 16+i) and read zero-extended to 64 bits.
- R3: Counter i (2 to 9) counts `evt_vec_i[code]`, where code is its 8-bit select field. Counters 2 to 5 take their fields from address 2 and counters 6 to 9 from address 3, each at bit offset (i - base) × 8, with base 2 or 6. Counters 0 and 1 have no select field.
- R4: Filter register (address 1): user enables for counters 0–7 in bits 7:0, kernel enables for 0–7 in bits 15:8, user enables for 8–9 in bits 33:32, kernel enables for 8–9 in bits 35:34. A counter counts only when the bit for the current level is set (`priv_kernel_i` = 1 means kernel).
- R5: Control register (address 0): counter enables for counters 0–7 in bits 7:0 and for 8–9 in bits 33:32. Interrupt enables for 0–7 in bits 23:16 and for 8–9 in bits 41:40. A disabled counter holds its value. Bits not listed read zero.
- R6: The overflow bit i (address 4, bits 9:0) is set on the cycle counter i's bit 47 changes from 0 to 1 by counting. Counters do not saturate: they roll over from 2^48-1 to 0, and the rollover itself sets nothing.
- R7: Writing 1 to an overflow bit clears it and writing 0 leaves it alone. A new overflow in the same cycle as the clear wins, and the bit stays set.
- R8: When a software write to a counter and a count fall in the same cycle, the written value is stored and the count is lost.
- R9: The interrupt mode sits in control bits 9:8: 0 off, 1 fast, 2 standard, 3 parked (treated as off). A request exists when some counter has both its overflow bit and its interrupt enable set and the mode is fast or standard. The request drives `irq_fast_o` in fast mode and `irq_std_o` in standard mode.
- R10: The interrupt-active flag (control bit 10) is set on the cycle after a request exists. Software clears it by writing 0 to that bit. A request in the same cycle as the clearing write keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 5 | Register address for both read and write |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Combinational read data for `reg_addr_i` |
| evt_vec_i | input | 256 | Event pulses, indexed by event code |
| inst_ret_i | input | 1 | Retired-instruction pulse counted by counter 1 |
| priv_kernel_i | input | 1 | Current level: 1 kernel, 0 user |
| irq_fast_o | output | 1 | Overflow request in fast mode |
| irq_std_o | output | 1 | Overflow request in standard mode |

## Verification
Assertions check these on every cycle:
- A counter written by software holds the written value at the next edge.
- A counter that neither counts nor is written keeps its value, and the all-ones value rolls over to zero.
- An overflow pulse always leaves bit 47 set.
- Overflow bits stay set unless cleared, and a new overflow always lands.
- An existing request always raises the active flag.
- The off and parked modes keep both request lines low, and the two lines are never high together.

Only the bench's scenarios can show three things. First, that the field layouts pick the right event code and the right filter bit for each counter. Second, that the W1C clear and a new overflow resolve in favour of the overflow when they land on the exact same cycle. Third, that a write colliding with a live event wins.

// File: rtl/pmu_bank_pkg.sv
package pmu_bank_pkg;
  localparam int NUM_CTR   = 10;
  localparam int LO_CNT    = 8;
  localparam int HI_CNT    = NUM_CTR - LO_CNT;
  localparam int FIXED_CTR = 2;
  localparam int SEL_CTR   = NUM_CTR - FIXED_CTR;
  localparam int SEL_PER_REG = 4;
  localparam int DATA_W    = 64;
  localparam int ADDR_W    = 5;
  localparam int CTR_BASE  = 16;

  localparam logic [ADDR_W-1:0] A_CTRL = 5'd0;
  localparam logic [ADDR_W-1:0] A_FILT = 5'd1;
  localparam logic [ADDR_W-1:0] A_SELA = 5'd2;
  localparam logic [ADDR_W-1:0] A_SELB = 5'd3;
  localparam logic [ADDR_W-1:0] A_OVF  = 5'd4;

  localparam int CTRL_EN_LO   = 0;
  localparam int CTRL_MODE    = 8;
  localparam int CTRL_ACT     = 10;
  localparam int CTRL_IE_LO   = 16;
  localparam int CTRL_EN_HI   = 32;
  localparam int CTRL_IE_HI   = 40;
  localparam int FILT_USR_LO  = 0;
  localparam int FILT_KRN_LO  = 8;
  localparam int FILT_USR_HI  = 32;
  localparam int FILT_KRN_HI  = 34;

  typedef enum logic [1:0] {
    IRQ_OFF  = 2'd0,
    IRQ_FAST = 2'd1,
    IRQ_STD  = 2'd2,
    IRQ_PARK = 2'd3
  } irq_mode_e;
endpackage

// File: rtl/pmu_ctrl_regs.sv
module pmu_ctrl_regs
  import pmu_bank_pkg::*;
#(
  parameter int EVT_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [NUM_CTR-1:0]            cnt_en_o,
  output logic [NUM_CTR-1:0]            irq_en_o,
  output logic [NUM_CTR-1:0]            usr_en_o,
  output logic [NUM_CTR-1:0]            krn_en_o,
  output logic [NUM_CTR-1:0][EVT_W-1:0] sel_o,
  output irq_mode_e                     mode_o,
  output logic [DATA_W-1:0]             ctrl_rd_o,
  output logic [DATA_W-1:0]             filt_rd_o,
  output logic [DATA_W-1:0]             sela_rd_o,
  output logic [DATA_W-1:0]             selb_rd_o
);
  logic [NUM_CTR-1:0]            cnt_en_q, irq_en_q, usr_en_q, krn_en_q;
  logic [SEL_CTR-1:0][EVT_W-1:0] sel_q;
  irq_mode_e                     mode_q;

  wire ctrl_hit = wr_i && (addr_i == A_CTRL);
  wire filt_hit = wr_i && (addr_i == A_FILT);
  wire sela_hit = wr_i && (addr_i == A_SELA);
  wire selb_hit = wr_i && (addr_i == A_SELB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_en_q <= '0;
      irq_en_q <= '0;
      mode_q   <= IRQ_OFF;
    end else if (ctrl_hit) begin
      cnt_en_q[LO_CNT-1:0]       <= wdata_i[CTRL_EN_LO +: LO_CNT];
      cnt_en_q[NUM_CTR-1:LO_CNT] <= wdata_i[CTRL_EN_HI +: HI_CNT];
      irq_en_q[LO_CNT-1:0]       <= wdata_i[CTRL_IE_LO +: LO_CNT];
      irq_en_q[NUM_CTR-1:LO_CNT] <= wdata_i[CTRL_IE_HI +: HI_CNT];
      mode_q                     <= irq_mode_e'(wdata_i[CTRL_MODE +: 2]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usr_en_q <= '0;
      krn_en_q <= '0;
    end else if (filt_hit) begin
      usr_en_q[LO_CNT-1:0]       <= wdata_i[FILT_USR_LO +: LO_CNT];
      krn_en_q[LO_CNT-1:0]       <= wdata_i[FILT_KRN_LO +: LO_CNT];
      usr_en_q[NUM_CTR-1:LO_CNT] <= wdata_i[FILT_USR_HI +: HI_CNT];
      krn_en_q[NUM_CTR-1:LO_CNT] <= wdata_i[FILT_KRN_HI +: HI_CNT];
    end
  end

  // Select fields: counters 2..5 in the first register, 6..9 in the second.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else begin
      for (int j = 0; j < SEL_CTR; j++) begin
        if (j < SEL_PER_REG) begin
          if (sela_hit) sel_q[j] <= wdata_i[j*EVT_W +: EVT_W];
        end else begin
          if (selb_hit) sel_q[j] <= wdata_i[(j-SEL_PER_REG)*EVT_W +: EVT_W];
        end
      end
    end
  end

  always_comb begin
    sela_rd_o = '0;
    selb_rd_o = '0;
    for (int j = 0; j < SEL_CTR; j++) begin
      if (j < SEL_PER_REG) sela_rd_o[j*EVT_W +: EVT_W] = sel_q[j];
      else                 selb_rd_o[(j-SEL_PER_REG)*EVT_W +: EVT_W] = sel_q[j];
    end
  end

  always_comb begin
    ctrl_rd_o = '0;
    ctrl_rd_o[CTRL_EN_LO +: LO_CNT] = cnt_en_q[LO_CNT-1:0];
    ctrl_rd_o[CTRL_EN_HI +: HI_CNT] = cnt_en_q[NUM_CTR-1:LO_CNT];
    ctrl_rd_o[CTRL_IE_LO +: LO_CNT] = irq_en_q[LO_CNT-1:0];
    ctrl_rd_o[CTRL_IE_HI +: HI_CNT] = irq_en_q[NUM_CTR-1:LO_CNT];
    ctrl_rd_o[CTRL_MODE +: 2]       = mode_q;
    filt_rd_o = '0;
    filt_rd_o[FILT_USR_LO +: LO_CNT] = usr_en_q[LO_CNT-1:0];
    filt_rd_o[FILT_KRN_LO +: LO_CNT] = krn_en_q[LO_CNT-1:0];
    filt_rd_o[FILT_USR_HI +: HI_CNT] = usr_en_q[NUM_CTR-1:LO_CNT];
    filt_rd_o[FILT_KRN_HI +: HI_CNT] = krn_en_q[NUM_CTR-1:LO_CNT];
  end

  generate
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_sel
      if (i < FIXED_CTR) begin : g_fixed
        assign sel_o[i] = '0;
      end else begin : g_prog
        assign sel_o[i] = sel_q[i-FIXED_CTR];
      end
    end
  endgenerate

  assign cnt_en_o = cnt_en_q;
  assign irq_en_o = irq_en_q;
  assign usr_en_o = usr_en_q;
  assign krn_en_o = krn_en_q;
  assign mode_o   = mode_q;

  // R5: a control write is visible on the enable outputs one edge later
  a_r5_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hit |=> cnt_en_o[LO_CNT-1:0] == $past(wdata_i[CTRL_EN_LO +: LO_CNT]));
endmodule

// File: rtl/pmu_counter_slice.sv
module pmu_counter_slice #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             event_i,
  input  logic             en_i,
  input  logic             usr_en_i,
  input  logic             krn_en_i,
  input  logic             priv_kernel_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] value_o,
  output logic             ovf_pulse_o
);
  localparam int MSB = CNT_W - 1;

  logic [CNT_W-1:0] value_q;
  logic [CNT_W-1:0] incr;
  logic             level_ok, inc;

  assign level_ok    = priv_kernel_i ? krn_en_i : usr_en_i;
  assign inc         = event_i && en_i && level_ok;
  assign incr        = value_q + CNT_W'(1);
  assign ovf_pulse_o = inc && !wr_i && !value_q[MSB] && incr[MSB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value_q <= '0;
    else if (wr_i)   value_q <= wdata_i;
    else if (inc)    value_q <= incr;
  end

  assign value_o = value_q;

  // R8: software write always lands, even with a live event
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> value_o == $past(wdata_i));
  // R5 / R4: no count and no write leaves the value alone
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !inc) |=> $stable(value_o));
  // R6: rollover from all ones to zero
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_i && (&value_o)) |=> value_o == '0);
  // R6: an overflow pulse leaves the top bit set
  a_r6_ovf_msb: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse_o |=> value_o[MSB]);
endmodule

// File: rtl/pmu_ovf_irq.sv
module pmu_ovf_irq
  import pmu_bank_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] ovf_pulse_i,
  input  logic [NUM_CTR-1:0] irq_en_i,
  input  irq_mode_e          mode_i,
  input  logic               clr_wr_i,
  input  logic [NUM_CTR-1:0] clr_mask_i,
  input  logic               act_wr_i,
  input  logic               act_wdata_i,
  output logic [NUM_CTR-1:0] ovf_o,
  output logic               act_o,
  output logic               irq_fast_o,
  output logic               irq_std_o
);
  logic [NUM_CTR-1:0] ovf_q, clr_eff, keep;
  logic               act_q, mode_on, req;

  assign clr_eff = clr_wr_i ? clr_mask_i : '0;
  assign keep    = ovf_q & ~clr_eff;
  assign mode_on = (mode_i == IRQ_FAST) || (mode_i == IRQ_STD);
  assign req     = mode_on && |(ovf_q & irq_en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= '0;
      act_q <= 1'b0;
    end else begin
      ovf_q <= keep | ovf_pulse_i;
      act_q <= (act_wr_i ? act_wdata_i : act_q) | req;
    end
  end

  assign ovf_o      = ovf_q;
  assign act_o      = act_q;
  assign irq_fast_o = req && (mode_i == IRQ_FAST);
  assign irq_std_o  = req && (mode_i == IRQ_STD);

  // R7: bits not cleared stay set
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ovf_o & $past(keep)) == $past(keep));
  // R7: a new overflow always lands, even against a clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf_pulse_i) |=> (ovf_o & $past(ovf_pulse_i)) == $past(ovf_pulse_i));
  // R10: a request raises the active flag
  a_r10_active: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> act_o);
  // R9: off and parked modes stay quiet; lines are exclusive
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == IRQ_OFF || mode_i == IRQ_PARK) |-> !(irq_fast_o || irq_std_o));
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_fast_o, irq_std_o}));
endmodule

// File: rtl/pmu_counter_bank.sv
module pmu_counter_bank
  import pmu_bank_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter int EVT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  input  logic [(1<<EVT_W)-1:0] evt_vec_i,
  input  logic                  inst_ret_i,
  input  logic                  priv_kernel_i,
  output logic                  irq_fast_o,
  output logic                  irq_std_o
);
  logic [NUM_CTR-1:0]            cnt_en, irq_en, usr_en, krn_en;
  logic [NUM_CTR-1:0][EVT_W-1:0] sel;
  irq_mode_e                     mode;
  logic [DATA_W-1:0]             ctrl_rd, filt_rd, sela_rd, selb_rd;
  logic [NUM_CTR-1:0][CNT_W-1:0] ctr_val;
  logic [NUM_CTR-1:0]            ovf_pulse, ovf_bits, ctr_evt, ctr_wr;
  logic                          act;

  pmu_ctrl_regs #(.EVT_W(EVT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .cnt_en_o  (cnt_en),
    .irq_en_o  (irq_en),
    .usr_en_o  (usr_en),
    .krn_en_o  (krn_en),
    .sel_o     (sel),
    .mode_o    (mode),
    .ctrl_rd_o (ctrl_rd),
    .filt_rd_o (filt_rd),
    .sela_rd_o (sela_rd),
    .selb_rd_o (selb_rd)
  );

  generate
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      if (i == 0) begin : g_cycles
        assign ctr_evt[i] = 1'b1;
      end else if (i == 1) begin : g_insts
        assign ctr_evt[i] = inst_ret_i;
      end else begin : g_select
        assign ctr_evt[i] = evt_vec_i[sel[i]];
      end
      assign ctr_wr[i] = reg_wr_i && (reg_addr_i == ADDR_W'(CTR_BASE + i));

      pmu_counter_slice #(.CNT_W(CNT_W)) u_slice (
        .clk           (clk),
        .rst_n         (rst_n),
        .event_i       (ctr_evt[i]),
        .en_i          (cnt_en[i]),
        .usr_en_i      (usr_en[i]),
        .krn_en_i      (krn_en[i]),
        .priv_kernel_i (priv_kernel_i),
        .wr_i          (ctr_wr[i]),
        .wdata_i       (reg_wdata_i[CNT_W-1:0]),
        .value_o       (ctr_val[i]),
        .ovf_pulse_o   (ovf_pulse[i])
      );
    end
  endgenerate

  pmu_ovf_irq u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ovf_pulse_i (ovf_pulse),
    .irq_en_i    (irq_en),
    .mode_i      (mode),
    .clr_wr_i    (reg_wr_i && (reg_addr_i == A_OVF)),
    .clr_mask_i  (reg_wdata_i[NUM_CTR-1:0]),
    .act_wr_i    (reg_wr_i && (reg_addr_i == A_CTRL)),
    .act_wdata_i (reg_wdata_i[CTRL_ACT]),
    .ovf_o       (ovf_bits),
    .act_o       (act),
    .irq_fast_o  (irq_fast_o),
    .irq_std_o   (irq_std_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o           = ctrl_rd;
        reg_rdata_o[CTRL_ACT] = act;
      end
      A_FILT: reg_rdata_o = filt_rd;
      A_SELA: reg_rdata_o = sela_rd;
      A_SELB: reg_rdata_o = selb_rd;
      A_OVF:  reg_rdata_o[NUM_CTR-1:0] = ovf_bits;
      default: begin
        for (int i = 0; i < NUM_CTR; i++)
          if (reg_addr_i == ADDR_W'(CTR_BASE + i)) reg_rdata_o = DATA_W'(ctr_val[i]);
      end
    endcase
  end

  // R2: counter 0 with enable and both filters advances by exactly one
  a_r2_cycle_count: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en[0] && usr_en[0] && krn_en[0] && !ctr_wr[0])
      |=> ctr_val[0] == $past(ctr_val[0]) + CNT_W'(1));
endmodule

// File: tb/pmu_counter_bank_tb.sv
`timescale 1ns/1ps
module pmu_counter_bank_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [4:0]   reg_addr = '0;
  logic [63:0]  reg_wdata = '0;
  logic [63:0]  reg_rdata;
  logic [255:0] evt = '0;
  logic         inst = 1'b0;
  logic         priv = 1'b0;
  logic         irq_fast, irq_std;

  always #2.5 clk = ~clk;

  pmu_counter_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .evt_vec_i(evt),
    .inst_ret_i(inst), .priv_kernel_i(priv),
    .irq_fast_o(irq_fast), .irq_std_o(irq_std)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R1";
  int inst_mode = 0;   // 0 random, 1 forced high
  int priv_mode = 0;   // 0 random, 1 user, 2 kernel

  // reference state
  logic [47:0] m_cnt [10];
  logic [7:0]  m_sel [10];
  logic [9:0]  m_en = '0, m_ie = '0, m_usr = '0, m_krn = '0, m_ovf = '0;
  logic [1:0]  m_mode = '0;
  logic        m_act = 1'b0;

  function automatic logic [63:0] mread(logic [4:0] a);
    logic [63:0] r = '0;
    case (a)
      5'd0: begin
        r[7:0] = m_en[7:0]; r[9:8] = m_mode; r[10] = m_act;
        r[23:16] = m_ie[7:0]; r[33:32] = m_en[9:8]; r[41:40] = m_ie[9:8];
      end
      5'd1: begin
        r[7:0] = m_usr[7:0]; r[15:8] = m_krn[7:0];
        r[33:32] = m_usr[9:8]; r[35:34] = m_krn[9:8];
      end
      5'd2: for (int k = 0; k < 4; k++) r[k*8 +: 8] = m_sel[k+2];
      5'd3: for (int k = 0; k < 4; k++) r[k*8 +: 8] = m_sel[k+6];
      5'd4: r[9:0] = m_ovf;
      default: if (a >= 16 && a < 26) r[47:0] = m_cnt[a-16];
    endcase
    return r;
  endfunction

  function automatic bit mreq();
    return ((m_mode == 2'd1) || (m_mode == 2'd2)) && (|(m_ovf & m_ie));
  endfunction

  task automatic mstep(logic w, logic [4:0] a, logic [63:0] d);
    logic [9:0] setv = '0;
    bit req = mreq();
    for (int i = 0; i < 10; i++) begin
      bit ev = (i == 0) ? 1'b1 : (i == 1) ? inst : evt[m_sel[i]];
      bit lv = priv ? m_krn[i] : m_usr[i];
      if (w && a == 5'(16 + i)) m_cnt[i] = d[47:0];
      else if (m_en[i] && lv && ev) begin
        logic [47:0] nv = m_cnt[i] + 48'd1;
        if (!m_cnt[i][47] && nv[47]) setv[i] = 1'b1;
        m_cnt[i] = nv;
      end
    end
    m_ovf = (m_ovf & ~((w && a == 5'd4) ? d[9:0] : 10'd0)) | setv;
    m_act = ((w && a == 5'd0) ? d[10] : m_act) | req;
    if (w && a == 5'd0) begin
      m_en = {d[33:32], d[7:0]}; m_ie = {d[41:40], d[23:16]}; m_mode = d[9:8];
    end
    if (w && a == 5'd1) begin
      m_usr = {d[33:32], d[7:0]}; m_krn = {d[35:34], d[15:8]};
    end
    if (w && a == 5'd2) for (int k = 0; k < 4; k++) m_sel[k+2] = d[k*8 +: 8];
    if (w && a == 5'd3) for (int k = 0; k < 4; k++) m_sel[k+6] = d[k*8 +: 8];
  endtask

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic w, logic [4:0] a, logic [63:0] d);
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d;
    evt  = {$urandom(), $urandom(), $urandom(), $urandom(),
            $urandom(), $urandom(), $urandom(), $urandom()};
    inst = (inst_mode == 1) ? 1'b1 : 1'($urandom_range(0, 1));
    priv = (priv_mode == 1) ? 1'b0 : (priv_mode == 2) ? 1'b1 : 1'($urandom_range(0, 1));
    #1;
    chk($sformatf("rdata@%0d", a), reg_rdata, mread(a));
    chk("irq", {62'd0, irq_fast, irq_std},
        {62'd0, mreq() && m_mode == 2'd1, mreq() && m_mode == 2'd2});
    mstep(w, a, d);
  endtask

  task automatic run(int n, int base, int span);
    for (int k = 0; k < n; k++) step(1'b0, 5'(base + (k % span)), 64'd0);
  endtask

  function automatic logic [63:0] ctrlw(logic [9:0] en, logic [9:0] ie,
                                        logic [1:0] mode, logic act);
    logic [63:0] r = '0;
    r[7:0] = en[7:0]; r[33:32] = en[9:8]; r[23:16] = ie[7:0];
    r[41:40] = ie[9:8]; r[9:8] = mode; r[10] = act;
    return r;
  endfunction

  function automatic logic [63:0] filtw(logic [9:0] u, logic [9:0] k);
    logic [63:0] r = '0;
    r[7:0] = u[7:0]; r[15:8] = k[7:0]; r[33:32] = u[9:8]; r[35:34] = k[9:8];
    return r;
  endfunction

  initial begin
    for (int i = 0; i < 10; i++) begin m_cnt[i] = '0; m_sel[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state of every address
    tag = "R1";
    for (int a = 0; a < 32; a++) step(1'b0, 5'(a), 64'd0);
    // R5: enables on, filters still off -> nothing counts
    tag = "R5";
    step(1'b1, 5'd0, ctrlw(10'h3FF, 10'h000, 2'd0, 1'b0));
    run(24, 16, 10);
    // R4: user-only then kernel-only on even counters
    tag = "R4";
    step(1'b1, 5'd1, filtw(10'h3FF, 10'h000));
    run(60, 16, 10);
    step(1'b1, 5'd1, filtw(10'h000, 10'h155));
    run(60, 16, 10);
    priv_mode = 1; run(10, 16, 10); priv_mode = 0;
    // R3: select fields pick event codes
    tag = "R3";
    step(1'b1, 5'd1, filtw(10'h3FF, 10'h3FF));
    step(1'b1, 5'd2, 64'h0000_0000_1312_1110);
    step(1'b1, 5'd3, 64'h0000_0000_FF80_4001);
    run(200, 16, 10);
    step(1'b0, 5'd2, 64'd0); step(1'b0, 5'd3, 64'd0);
    // R2: fixed counters
    tag = "R2";
    run(40, 16, 2);
    // R5: partial disable holds values
    tag = "R5";
    step(1'b1, 5'd0, ctrlw(10'h2AA, 10'h000, 2'd0, 1'b0));
    run(40, 16, 10);
    step(1'b1, 5'd0, ctrlw(10'h3FF, 10'h000, 2'd0, 1'b0));
    // R6: overflow on bit 47 and rollover
    tag = "R6";
    step(1'b1, 5'd20, 64'h0000_7FFF_FFFF_FFFD);
    step(1'b1, 5'd16, 64'h0000_7FFF_FFFF_FFFE);
    run(16, 4, 1);
    step(1'b1, 5'd16, 64'h0000_FFFF_FFFF_FFFE);
    run(6, 16, 1);
    run(2, 4, 1);
    // R9: interrupt modes
    tag = "R9";
    step(1'b1, 5'd0, ctrlw(10'h3FF, 10'h011, 2'd1, 1'b0));
    run(4, 0, 1);
    step(1'b1, 5'd0, ctrlw(10'h3FF, 10'h011, 2'd2, 1'b1));
    run(4, 0, 1);
    step(1'b1, 5'd0, ctrlw(10'h3FF, 10'h011, 2'd3, 1'b1));
    run(4, 0, 1);
    // R10: clearing the active flag with and without a live request
    tag = "R10";
    step(1'b1, 5'd0, ctrlw(10'h3FF, 10'h011, 2'd0, 1'b0));
    run(3, 0, 1);
    step(1'b1, 5'd0, ctrlw(10'h3FF, 10'h011, 2'd1, 1'b0));
    step(1'b1, 5'd0, ctrlw(10'h3FF, 10'h011, 2'd1, 1'b0));
    run(3, 0, 1);
    // R7: W1C, and a new overflow beating a clear in the same cycle
    tag = "R7";
    step(1'b1, 5'd4, 64'h3FF);
    step(1'b1, 5'd4, 64'h3FF);
    run(2, 4, 1);
    step(1'b1, 5'd16, 64'h0000_7FFF_FFFF_FFFE);
    step(1'b0, 5'd16, 64'd0);
    step(1'b1, 5'd4, 64'h001);
    run(3, 4, 1);
    step(1'b1, 5'd4, 64'h000);
    run(2, 4, 1);
    // R8: write against a live event
    tag = "R8";
    inst_mode = 1;
    step(1'b1, 5'd17, 64'h0000_0000_0000_0123);
    run(3, 17, 1);
    step(1'b1, 5'd17, 64'hFFFF_0000_0000_0456);
    run(3, 17, 1);
    inst_mode = 0;
    run(30, 0, 26);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired in phase %s actual=hung expected=done", tag);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule